// File: doc/BRIEF.md
# Subroutine Stack and Return-Address Unit

This unit owns the stack pointer of a 16-bit processor whose instructions are all four bytes long. When the processor calls a subroutine, the unit stores the return address in data memory. When the processor returns, it reads that address back. It also carries out register push and pop. The stack grows toward higher addresses: a store uses the current pointer and then advances it by one 2-byte slot, and a load first steps the pointer back by one slot and then reads.

The unit has one data-memory port. The memory has a read latency of one cycle. The unit drives the address, the write data and the write and read enables. On every call or return it presents the new program counter together with a write strobe. Besides the memory operations it can copy the stack pointer into a general register, copy a register into the stack pointer, and load the stack pointer from an immediate address. The two copies record whether the copied value was zero. The stack pointer and the program counter are unsigned 16-bit addresses, and all pointer arithmetic wraps modulo 2^16.

Instruction decode and the register file sit outside the unit. The decoder issues one operation at a time with `opValid` and waits while `busy` is high.

Top module: `call_stack_unit`

## Requirements
- R1: After reset the stack pointer is 0x0000 and the zero flag is 0. `busy`, `pcWe`, `memWe`, `memRe` and `regWe` are all low.
- R2: CALL (opCode 1) takes two cycles. In the accept cycle the unit writes `pcIn`+4 to address SP. In the next cycle `busy` is high and `pcWe` pulses with `pcOut` equal to `target`. From the following cycle on, SP has grown by 2.
- R3: RET (opCode 2) takes two cycles. In the accept cycle the unit reads address SP-2. In the next cycle `pcWe` pulses with `pcOut` equal to the word read. After that, SP has dropped by 2.
- R4: PUSH (opCode 3) writes `regIn` to address SP in the accept cycle. After the second cycle, SP has grown by 2.
- R5: POP (opCode 4) reads address SP-2 in the accept cycle. In the second cycle it pulses `regWe` with `regOut` equal to the word read. After that, SP has dropped by 2.
- R6: SP-to-register copy (opCode 5) pulses `regWe` with `regOut` equal to SP in the accept cycle. From the next cycle on, the zero flag is 1 exactly when that SP was zero.
- R7: Register-to-SP copy (opCode 6) makes SP equal to `regIn` from the next cycle on. The zero flag becomes 1 exactly when `regIn` was zero.
- R8: Immediate SP load (opCode 7) makes SP equal to `target` from the next cycle on and leaves the zero flag unchanged.
- R9: SP wraps modulo 2^16. A push at 0xFFFE leaves SP at 0x0000. A pop at 0x0000 reads address 0xFFFE.
- R10: An operation offered while `busy` is high is ignored. SP, PC and memory see no effect from it.
- R11: Nested calls return in last-in, first-out order, each to its own call address plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation offered this cycle |
| opCode | input | 3 | Operation: 0 none, 1 call, 2 return, 3 push, 4 pop, 5 SP to register, 6 register to SP, 7 load SP |
| pcIn | input | 16 | Address of the current instruction |
| target | input | 16 | Call target or immediate SP value |
| regIn | input | 16 | Register value for push or register-to-SP copy |
| memRdata | input | 16 | Read data, valid one cycle after a read request |
| memAddr | output | 16 | Byte address of the memory access |
| memWdata | output | 16 | Write data |
| memWe | output | 1 | Write request |
| memRe | output | 1 | Read request |
| pcOut | output | 16 | New program counter |
| pcWe | output | 1 | `pcOut` is valid this cycle |
| spOut | output | 16 | Current stack pointer |
| regOut | output | 16 | Value to write to the destination register |
| regWe | output | 1 | `regOut` is valid this cycle |
| zFlag | output | 1 | Zero flag from the last register copy |
| busy | output | 1 | Second cycle of a two-cycle operation |

## Verification
The hardest case to reach from the ports is an operation offered during the second cycle of a memory operation. The decoder never does this, yet the state would be corrupted if the offer were accepted. The bench raises `opValid` with an immediate SP load in exactly that cycle, right after a push. It then checks that SP shows only the push step and that no memory request appears. The bench also drives SP across the 0xFFFE/0x0000 boundary by loading it directly. With SP there, it confirms that both the push address and the pop address wrap.

// File: rtl/call_stack_pkg.sv
package call_stack_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_CALL   = 3'd1,
    OP_RET    = 3'd2,
    OP_PUSH   = 3'd3,
    OP_POP    = 3'd4,
    OP_SP2REG = 3'd5,
    OP_REG2SP = 3'd6,
    OP_LDSP   = 3'd7
  } csu_op_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_FINISH = 1'b1
  } csu_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic memWr;
    logic memRd;
    logic addrDec;
    logic wdataPc;
    logic latchTarget;
    logic spInc;
    logic spDec;
    logic spLoadReg;
    logic spLoadImm;
    logic pcFromMem;
    logic pcWe;
    logic regFromMem;
    logic regWe;
    logic zCapture;
  } csu_strb_t;

endpackage

// File: rtl/call_stack_ctrl.sv
module call_stack_ctrl
  import call_stack_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      opValid,
  input  csu_op_e   opCode,
  output csu_strb_t strb,
  output logic      busy
);

  csu_state_e state, nextState;
  csu_op_e    pendOp, nextOp;

  always_comb begin
    strb      = '0;
    nextState = state;
    nextOp    = pendOp;
    case (state)
      ST_IDLE: begin
        if (opValid) begin
          case (opCode)
            OP_CALL: begin
              strb.memWr       = 1'b1;
              strb.wdataPc     = 1'b1;
              strb.latchTarget = 1'b1;
              nextState        = ST_FINISH;
              nextOp           = opCode;
            end
            OP_RET: begin
              strb.memRd   = 1'b1;
              strb.addrDec = 1'b1;
              nextState    = ST_FINISH;
              nextOp       = opCode;
            end
            OP_PUSH: begin
              strb.memWr = 1'b1;
              nextState  = ST_FINISH;
              nextOp     = opCode;
            end
            OP_POP: begin
              strb.memRd   = 1'b1;
              strb.addrDec = 1'b1;
              nextState    = ST_FINISH;
              nextOp       = opCode;
            end
            OP_SP2REG: begin
              strb.regWe    = 1'b1;
              strb.zCapture = 1'b1;
            end
            OP_REG2SP: begin
              strb.spLoadReg = 1'b1;
              strb.zCapture  = 1'b1;
            end
            OP_LDSP: strb.spLoadImm = 1'b1;
            default: ;
          endcase
        end
      end
      ST_FINISH: begin
        nextState = ST_IDLE;
        case (pendOp)
          OP_CALL: begin
            strb.spInc = 1'b1;
            strb.pcWe  = 1'b1;
          end
          OP_RET: begin
            strb.spDec     = 1'b1;
            strb.pcFromMem = 1'b1;
            strb.pcWe      = 1'b1;
          end
          OP_PUSH: strb.spInc = 1'b1;
          OP_POP: begin
            strb.spDec      = 1'b1;
            strb.regFromMem = 1'b1;
            strb.regWe      = 1'b1;
          end
          default: ;
        endcase
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      pendOp <= OP_NONE;
    end else begin
      state  <= nextState;
      pendOp <= nextOp;
    end
  end

  assign busy = (state == ST_FINISH);

  // R2
  call_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && opValid && opCode == OP_CALL) |=> (strb.pcWe && strb.spInc));

  // R3
  ret_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && opValid && opCode == OP_RET) |=> (strb.pcFromMem && strb.spDec));

  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.memWr || strb.memRd || strb.spLoadReg || strb.spLoadImm));

  // R10
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.memWr, strb.memRd, strb.spLoadReg, strb.spLoadImm, strb.spInc, strb.spDec}));

endmodule

// File: rtl/call_stack_dp.sv
module call_stack_dp
  import call_stack_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int INSTR_BYTES = 4,
  parameter int SLOT_BYTES  = 2,
  parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  csu_strb_t         strb,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] regIn,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic [ADDR_W-1:0] regOut,
  output logic              zFlag
);

  localparam logic [ADDR_W-1:0] SLOT_STEP  = ADDR_W'(SLOT_BYTES);
  localparam logic [ADDR_W-1:0] INSTR_STEP = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] spQ, targetQ, spBelow, copyVal;
  logic              zQ;

  assign spBelow  = spQ - SLOT_STEP;
  assign memAddr  = strb.addrDec ? spBelow : spQ;
  assign memWdata = strb.wdataPc ? (pcIn + INSTR_STEP) : regIn;
  assign pcOut    = strb.pcFromMem ? memRdata : targetQ;
  assign regOut   = strb.regFromMem ? memRdata : spQ;
  assign copyVal  = strb.spLoadReg ? regIn : spQ;
  assign spOut    = spQ;
  assign zFlag    = zQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spQ     <= SP_RESET;
      targetQ <= '0;
      zQ      <= 1'b0;
    end else begin
      if (strb.latchTarget) targetQ <= target;
      if (strb.zCapture)    zQ      <= (copyVal == '0);
      if (strb.spInc)          spQ <= spQ + SLOT_STEP;
      else if (strb.spDec)     spQ <= spBelow;
      else if (strb.spLoadReg) spQ <= regIn;
      else if (strb.spLoadImm) spQ <= target;
    end
  end

  // R4
  sp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.spInc |=> (spQ == $past(spQ) + SLOT_STEP));

  // R5
  sp_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.spDec |=> (spQ == $past(spQ) - SLOT_STEP));

  // R8
  sp_imm_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.spLoadImm |=> (spQ == $past(target) && $stable(zQ)));

  // R7
  zflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.spLoadReg |=> (zQ == ($past(regIn) == '0)));

endmodule

// File: rtl/call_stack_unit.sv
module call_stack_unit
  import call_stack_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int INSTR_BYTES = 4,
  parameter int SLOT_BYTES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] regIn,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] pcOut,
  output logic              pcWe,
  output logic [ADDR_W-1:0] spOut,
  output logic [ADDR_W-1:0] regOut,
  output logic              regWe,
  output logic              zFlag,
  output logic              busy
);

  csu_strb_t strb;

  call_stack_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (csu_op_e'(opCode)),
    .strb    (strb),
    .busy    (busy)
  );

  call_stack_dp #(
    .ADDR_W      (ADDR_W),
    .INSTR_BYTES (INSTR_BYTES),
    .SLOT_BYTES  (SLOT_BYTES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pcIn     (pcIn),
    .target   (target),
    .regIn    (regIn),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .pcOut    (pcOut),
    .spOut    (spOut),
    .regOut   (regOut),
    .zFlag    (zFlag)
  );

  assign memWe = strb.memWr;
  assign memRe = strb.memRd;
  assign pcWe  = strb.pcWe;
  assign regWe = strb.regWe;

endmodule

// File: tb/test_call_stack_unit.sv
`timescale 1ns/1ps
module test_call_stack_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [15:0] pcIn = '0, target = '0, regIn = '0, memRdata;
  logic [15:0] memAddr, memWdata, pcOut, spOut, regOut;
  logic        memWe, memRe, pcWe, regWe, zFlag, busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] expSp = 16'h0000;

  logic [15:0] ram [256];
  logic [15:0] rdQ = '0;
  assign memRdata = rdQ;

  always #2.5 clk = ~clk;

  call_stack_unit i_call_stack_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .pcIn(pcIn), .target(target), .regIn(regIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .pcOut(pcOut), .pcWe(pcWe), .spOut(spOut), .regOut(regOut),
    .regWe(regWe), .zFlag(zFlag), .busy(busy)
  );

  // external RAM with one-cycle read latency
  always @(posedge clk) begin
    if (memWe) ram[memAddr[8:1]] <= memWdata;
    if (memRe) rdQ <= ram[memAddr[8:1]];
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 sp", spOut, 16'h0000);
    chk("R1 z", 16'(zFlag), 16'h0);
    chk("R1 busy", 16'(busy), 16'h0);
    chk("R1 strobes", 16'({pcWe, memWe, memRe, regWe}), 16'h0);
  endtask

  task automatic do_call(input logic [15:0] pc, input logic [15:0] tgt);
    @(negedge clk); opValid = 1; opCode = 3'd1; pcIn = pc; target = tgt; #1;
    chk("R2 memWe", 16'(memWe), 16'h1);
    chk("R2 addr", memAddr, expSp);
    chk("R2 data", memWdata, 16'(pc + 16'd4));
    @(negedge clk); opValid = 0; #1;
    chk("R2 busy", 16'(busy), 16'h1);
    chk("R2 pcWe", 16'(pcWe), 16'h1);
    chk("R2 pcOut", pcOut, tgt);
    @(negedge clk); #1;
    expSp = expSp + 16'd2;
    chk("R2 sp", spOut, expSp);
    chk("R2 pcWe low", 16'(pcWe), 16'h0);
  endtask

  task automatic do_ret(input logic [15:0] expPc);
    @(negedge clk); opValid = 1; opCode = 3'd2; #1;
    chk("R3 memRe", 16'(memRe), 16'h1);
    chk("R3 addr", memAddr, 16'(expSp - 16'd2));
    @(negedge clk); opValid = 0; #1;
    chk("R3 pcWe", 16'(pcWe), 16'h1);
    chk("R3 R11 pcOut", pcOut, expPc);
    @(negedge clk); #1;
    expSp = expSp - 16'd2;
    chk("R3 sp", spOut, expSp);
  endtask

  task automatic do_push(input logic [15:0] val);
    @(negedge clk); opValid = 1; opCode = 3'd3; regIn = val; #1;
    chk("R4 memWe", 16'(memWe), 16'h1);
    chk("R4 addr", memAddr, expSp);
    chk("R4 data", memWdata, val);
    @(negedge clk); opValid = 0; #1;
    @(negedge clk); #1;
    expSp = expSp + 16'd2;
    chk("R4 sp", spOut, expSp);
  endtask

  task automatic do_pop(input logic [15:0] expVal);
    @(negedge clk); opValid = 1; opCode = 3'd4; #1;
    chk("R5 memRe", 16'(memRe), 16'h1);
    chk("R5 addr", memAddr, 16'(expSp - 16'd2));
    @(negedge clk); opValid = 0; #1;
    chk("R5 regWe", 16'(regWe), 16'h1);
    chk("R5 regOut", regOut, expVal);
    @(negedge clk); #1;
    expSp = expSp - 16'd2;
    chk("R5 sp", spOut, expSp);
  endtask

  task automatic do_sp2reg();
    @(negedge clk); opValid = 1; opCode = 3'd5; #1;
    chk("R6 regWe", 16'(regWe), 16'h1);
    chk("R6 regOut", regOut, expSp);
    @(negedge clk); opValid = 0; #1;
    chk("R6 z", 16'(zFlag), 16'(expSp == 16'h0));
  endtask

  task automatic do_reg2sp(input logic [15:0] v);
    @(negedge clk); opValid = 1; opCode = 3'd6; regIn = v; #1;
    @(negedge clk); opValid = 0; #1;
    expSp = v;
    chk("R7 sp", spOut, v);
    chk("R7 z", 16'(zFlag), 16'(v == 16'h0));
  endtask

  task automatic do_ldsp(input logic [15:0] v);
    logic zBefore;
    @(negedge clk); #1; zBefore = zFlag;
    opValid = 1; opCode = 3'd7; target = v;
    @(negedge clk); opValid = 0; #1;
    expSp = v;
    chk("R8 sp", spOut, v);
    chk("R8 z kept", 16'(zFlag), 16'(zBefore));
  endtask

  task automatic t_busy_ignore();
    logic [15:0] spStart;
    spStart = expSp;
    @(negedge clk); opValid = 1; opCode = 3'd3; regIn = 16'hA5A5; #1;
    @(negedge clk); opCode = 3'd7; target = 16'h7777; #1;
    chk("R10 busy", 16'(busy), 16'h1);
    chk("R10 no mem", 16'({memWe, memRe}), 16'h0);
    @(negedge clk); opValid = 0; #1;
    expSp = spStart + 16'd2;
    chk("R10 sp", spOut, expSp);
    @(negedge clk); #1;
    chk("R10 sp later", spOut, expSp);
  endtask

  task automatic t_nested();
    do_ldsp(16'h0100);
    do_call(16'h0200, 16'h0400);
    do_call(16'h0404, 16'h0800);
    do_push(16'h1234);
    do_pop(16'h1234);
    // R11: innermost call returns first
    do_ret(16'h0408);
    do_ret(16'h0204);
    chk("R11 sp home", spOut, 16'h0100);
  endtask

  task automatic t_wrap();
    do_ldsp(16'hFFFE);
    do_push(16'hBEEF);
    chk("R9 push wrap", spOut, 16'h0000);
    @(negedge clk); opValid = 1; opCode = 3'd4; #1;
    chk("R9 pop addr", memAddr, 16'hFFFE);
    @(negedge clk); opValid = 0; #1;
    chk("R9 pop data", regOut, 16'hBEEF);
    @(negedge clk); #1;
    expSp = 16'hFFFE;
    chk("R9 pop sp", spOut, 16'hFFFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_nested();
    do_sp2reg();
    do_reg2sp(16'h0000);
    do_sp2reg();
    do_ldsp(16'h0100);
    do_reg2sp(16'h5555);
    do_sp2reg();
    t_busy_ignore();
    t_wrap();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule